// File: doc/BRIEF.md
# Multi-Grant Round-Robin Output Scheduler

This block arbitrates for one output port of a switch whose inputs reach each output over several internal crossbar links. At every time slot it takes a request vector, one bit per input controller, and answers with an acknowledge vector that grants as many requesters as there are links. Each granted input is also told which internal link it has been given.

The scan for requesters starts at a fairness pointer and wraps around the input range. Requesters are granted in the order they are met until the links run out. When every requester fits, the pointer moves to just past the last one granted. When some requesters are refused, the pointer moves onto the first refused one, so that input is served first in the next slot. The request vector is sampled on a slot strobe. The acknowledge and link outputs are registered and hold their value until the next strobe.

Top module: `mlrr_sched`

## Requirements
- R1: After a slot strobe, the number of set acknowledge bits equals the smaller of N_LINKS and the number of request bits that were set at that strobe.
- R2: An acknowledge bit is set only for an input whose request bit was set at the strobe that produced it.
- R3: The scan starts at the fairness pointer (0 after reset) and proceeds through indices pointer, pointer+1, and so on, modulo N_PORTS. The granted inputs are the first requesters met in that order.
- R4: When every requester of a slot is granted, the pointer for the next slot becomes one past the highest-scanned granted index, modulo N_PORTS.
- R5: When at least one requester of a slot is refused, the pointer for the next slot becomes the index of the first refused requester in scan order.
- R6: Input i's link field is `link_o[i*LW +: LW]`, with LW = clog2(N_LINKS), or 1 when N_LINKS is 1. Granted inputs get link numbers 0, 1, 2 and so on in scan order. The field of an input that is not granted is 0.
- R7: A strobe with an all-zero request vector gives an all-zero acknowledge vector and leaves the pointer unchanged.
- R8: Acknowledge and link outputs change only on the clock edge where `slot_i` is high. Request changes between strobes have no effect on them.
- R9: While reset is held and after its release, the acknowledge and link outputs are zero and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_i | input | 1 | Slot strobe; requests are sampled on the rising edge where it is high |
| req_i | input | N_PORTS | One request bit per input controller |
| ack_o | output | N_PORTS | One acknowledge bit per input, valid for the slot |
| link_o | output | N_PORTS*LW | Per-input assigned link number, LW bits per input |

## Verification
The bench drives a 4-input, 2-link configuration through every request pattern. It repeats the patterns many times in a scrambled order, so each pattern is met at every pointer position. It tracks the pointer in its own model and compares the full acknowledge and link vectors after every strobe.

The corner cases it targets are:
- Wrap-around scans, where a design that forgets the modulo skips or duplicates low indices.
- Slots with exactly N_LINKS requesters, where an off-by-one in the refused-requester test moves the pointer to the wrong place.
- Idle slots, where a careless pointer update drifts.
- Request changes between strobes, which a design that is not registered would leak to the outputs.

// File: rtl/mlrr_pkg.sv
package mlrr_pkg;

   // Width of a link number field; a single link still needs one bit.
   function automatic int link_w(input int n_links);
      return (n_links > 1) ? $clog2(n_links) : 1;
   endfunction

   // Width of a port index.
   function automatic int idx_w(input int n_ports);
      return (n_ports > 1) ? $clog2(n_ports) : 1;
   endfunction

   // Width of a running request count (0 .. n_ports).
   function automatic int cnt_w(input int n_ports);
      return $clog2(n_ports + 1);
   endfunction

endpackage

// File: rtl/mlrr_rotate.sv
// Circular rotation of N fields of W bits by a runtime amount.
// REVERSE = 0: out[j] = in[(j + amt) mod N]   (align pointer to slot 0)
// REVERSE = 1: out[i] = in[(i - amt) mod N]   (undo the alignment)
module mlrr_rotate #(
   parameter int N       = 8,
   parameter int W       = 1,
   parameter int AW      = 3,
   parameter bit REVERSE = 1'b0
) (
   input  logic [N*W-1:0] vec_i,
   input  logic [AW-1:0]  amt_i,
   output logic [N*W-1:0] vec_o
);

   localparam int DW = 2 * N * W;

   logic [DW-1:0] dbl;
   logic [DW-1:0] moved;
   logic [31:0]   sh;

   assign dbl = {vec_i, vec_i};
   assign sh  = W * 32'(amt_i);

   generate
      if (REVERSE) begin : g_rev
         assign moved = dbl << sh;
         assign vec_o = moved[DW-1:N*W];
      end else begin : g_fwd
         assign moved = dbl >> sh;
         assign vec_o = moved[N*W-1:0];
      end
   endgenerate

endmodule

// File: rtl/mlrr_rank.sv
// Works on the request vector already rotated so that position 0 is the
// pointer. Ranks each requester by the number of requesters ahead of it,
// grants those ranked below N_LINKS, and locates the first refused one
// and the last requester.
module mlrr_rank #(
   parameter int N_PORTS = 8,
   parameter int N_LINKS = 2,
   parameter int LW      = mlrr_pkg::link_w(N_LINKS),
   parameter int PW      = mlrr_pkg::idx_w(N_PORTS),
   parameter int CW      = mlrr_pkg::cnt_w(N_PORTS)
) (
   input  logic [N_PORTS-1:0]    req_i,
   output logic [N_PORTS-1:0]    gnt_o,
   output logic [N_PORTS*LW-1:0] link_o,
   output logic                  any_o,
   output logic                  cut_hit_o,
   output logic [PW-1:0]         cut_pos_o,
   output logic [PW-1:0]         last_pos_o
);

   logic [CW-1:0]      cnt      [N_PORTS+1];
   logic [PW-1:0]      cut_acc  [N_PORTS+1];
   logic [PW-1:0]      last_acc [N_PORTS+1];
   logic [N_PORTS-1:0] cut_vec;
   logic [N_PORTS-1:0] last_vec;

   assign cnt[0]      = '0;
   assign cut_acc[0]  = '0;
   assign last_acc[0] = '0;

   genvar j;
   generate
      for (j = 0; j < N_PORTS; j++) begin : g_pos
         assign cnt[j+1]    = cnt[j] + CW'(req_i[j]);
         assign gnt_o[j]    = req_i[j] && (cnt[j] < CW'(N_LINKS));
         assign cut_vec[j]  = req_i[j] && (cnt[j] == CW'(N_LINKS));
         assign last_vec[j] = req_i[j] && (cnt[j+1] == cnt[N_PORTS]);
         assign link_o[j*LW +: LW] = gnt_o[j] ? cnt[j][LW-1:0] : '0;
         assign cut_acc[j+1]  = cut_acc[j]  | (cut_vec[j]  ? PW'(j) : '0);
         assign last_acc[j+1] = last_acc[j] | (last_vec[j] ? PW'(j) : '0);
      end
   endgenerate

   assign any_o      = (cnt[N_PORTS] != '0);
   assign cut_hit_o  = |cut_vec;
   assign cut_pos_o  = cut_acc[N_PORTS];
   assign last_pos_o = last_acc[N_PORTS];

   always_comb begin
      assert ($onehot0(cut_vec));
      assert ($onehot0(last_vec));
   end

endmodule

// File: rtl/mlrr_ptr.sv
// Fairness pointer. Offsets are relative to the current pointer.
module mlrr_ptr #(
   parameter int N_PORTS = 8,
   parameter int PW      = mlrr_pkg::idx_w(N_PORTS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          slot_i,
   input  logic          any_i,
   input  logic          cut_hit_i,
   input  logic [PW-1:0] cut_pos_i,
   input  logic [PW-1:0] last_pos_i,
   output logic [PW-1:0] ptr_o
);

   logic [PW:0]   off;
   logic [PW:0]   sum;
   logic [PW-1:0] nxt;

   always_comb begin
      off = cut_hit_i ? {1'b0, cut_pos_i} : ({1'b0, last_pos_i} + 1'b1);
      sum = {1'b0, ptr_o} + off;
      if (sum >= (PW+1)'(N_PORTS)) sum = sum - (PW+1)'(N_PORTS);
      nxt = sum[PW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 ptr_o <= '0;
      else if (slot_i && any_i)   ptr_o <= nxt;
   end

   AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_o < PW'(N_PORTS - 1) || ptr_o == PW'(N_PORTS - 1));   // R3
   AST_PTR_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_i && !any_i) |=> $stable(ptr_o));                    // R7
   AST_PTR_NO_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_i |=> $stable(ptr_o));                               // R8

endmodule

// File: rtl/mlrr_sched.sv
module mlrr_sched #(
   parameter int N_PORTS = 8,
   parameter int N_LINKS = 2
) (
   input  logic                                          clk,
   input  logic                                          rst_n,
   input  logic                                          slot_i,
   input  logic [N_PORTS-1:0]                            req_i,
   output logic [N_PORTS-1:0]                            ack_o,
   output logic [N_PORTS*mlrr_pkg::link_w(N_LINKS)-1:0]  link_o
);

   localparam int LW = mlrr_pkg::link_w(N_LINKS);
   localparam int PW = mlrr_pkg::idx_w(N_PORTS);

   generate
      if (N_PORTS < 2) begin : g_bad_ports
         $error("mlrr_sched: N_PORTS must be at least 2");
      end
      if (N_LINKS < 1 || N_LINKS > N_PORTS) begin : g_bad_links
         $error("mlrr_sched: N_LINKS must lie in 1..N_PORTS");
      end
   endgenerate

   logic [PW-1:0]         ptr;
   logic [N_PORTS-1:0]    req_rot;
   logic [N_PORTS-1:0]    gnt_rot;
   logic [N_PORTS*LW-1:0] link_rot;
   logic [N_PORTS-1:0]    gnt_nat;
   logic [N_PORTS*LW-1:0] link_nat;
   logic                  any_req;
   logic                  cut_hit;
   logic [PW-1:0]         cut_pos;
   logic [PW-1:0]         last_pos;

   mlrr_rotate #(.N(N_PORTS), .W(1), .AW(PW), .REVERSE(1'b0)) i_rot_req (
      .vec_i(req_i), .amt_i(ptr), .vec_o(req_rot));

   mlrr_rank #(.N_PORTS(N_PORTS), .N_LINKS(N_LINKS)) i_rank (
      .req_i      (req_rot),
      .gnt_o      (gnt_rot),
      .link_o     (link_rot),
      .any_o      (any_req),
      .cut_hit_o  (cut_hit),
      .cut_pos_o  (cut_pos),
      .last_pos_o (last_pos));

   mlrr_rotate #(.N(N_PORTS), .W(1), .AW(PW), .REVERSE(1'b1)) i_rot_gnt (
      .vec_i(gnt_rot), .amt_i(ptr), .vec_o(gnt_nat));

   mlrr_rotate #(.N(N_PORTS), .W(LW), .AW(PW), .REVERSE(1'b1)) i_rot_link (
      .vec_i(link_rot), .amt_i(ptr), .vec_o(link_nat));

   mlrr_ptr #(.N_PORTS(N_PORTS)) i_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .slot_i     (slot_i),
      .any_i      (any_req),
      .cut_hit_i  (cut_hit),
      .cut_pos_i  (cut_pos),
      .last_pos_i (last_pos),
      .ptr_o      (ptr));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_o  <= '0;
         link_o <= '0;
      end else if (slot_i) begin
         ack_o  <= gnt_nat;
         link_o <= link_nat;
      end
   end

   AST_GRANT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(ack_o) <= N_LINKS);                                        // R1
   AST_GRANT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      slot_i |=> ($countones(ack_o) ==
                  (($countones($past(req_i)) < N_LINKS) ?
                   $countones($past(req_i)) : N_LINKS)));                    // R1
   AST_GRANT_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
      slot_i |=> ((ack_o & ~$past(req_i)) == '0));                           // R2
   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_i && req_i == '0) |=> (ack_o == '0 && link_o == '0));            // R7
   AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_i |=> ($stable(ack_o) && $stable(link_o)));                      // R8

endmodule

// File: tb/test_mlrr_sched.sv
module test_mlrr_sched;

   localparam int N   = 4;
   localparam int M   = 2;
   localparam int LW  = 1;
   localparam int CLK = 10;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            slot_i = 1'b0;
   logic [N-1:0]    req_i = '0;
   logic [N-1:0]    ack_o;
   logic [N*LW-1:0] link_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   int           m_ptr = 0;
   string        m_tag = "R3";
   logic [N-1:0]    exp_ack;
   logic [N*LW-1:0] exp_link;

   always #(CLK/2) clk = ~clk;

   mlrr_sched #(.N_PORTS(N), .N_LINKS(M)) i_mlrr_sched (
      .clk(clk), .rst_n(rst_n), .slot_i(slot_i), .req_i(req_i),
      .ack_o(ack_o), .link_o(link_o));

   task automatic check(input string req, input bit ok, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Bench model; returns tag naming the pointer rule that applies next.
   function automatic string model(input logic [N-1:0] r);
      int cnt = 0;
      int last = 0;
      int first_ref = -1;
      exp_ack = '0;
      exp_link = '0;
      for (int j = 0; j < N; j++) begin
         int idx = (m_ptr + j) % N;
         if (r[idx]) begin
            if (cnt < M) begin
               exp_ack[idx] = 1'b1;
               exp_link[idx*LW +: LW] = LW'(cnt);
               last = idx;
            end else if (first_ref < 0) begin
               first_ref = idx;
            end
            cnt++;
         end
      end
      if (first_ref >= 0) begin m_ptr = first_ref; return "R5"; end
      if (cnt > 0) begin m_ptr = (last + 1) % N; return "R4"; end
      return "R7";
   endfunction

   task automatic do_slot(input logic [N-1:0] r);
      string nxt;
      int    pc;
      @(negedge clk);
      req_i  = r;
      slot_i = 1'b1;
      @(negedge clk);
      slot_i = 1'b0;
      pc = $countones(r);
      nxt = model(r);
      check($sformatf("%s ack match req=%0h", m_tag, r), ack_o == exp_ack, ack_o, exp_ack);
      check("R1 grant count", $countones(ack_o) == ((pc < M) ? pc : M),
            $countones(ack_o), (pc < M) ? pc : M);
      check("R2 grant subset", (ack_o & ~r) == '0, ack_o, r);
      check("R6 link numbers", link_o == exp_link, link_o, exp_link);
      if (r == '0) check("R7 idle ack zero", ack_o == '0, ack_o, 0);
      m_tag = (nxt == "R7") ? m_tag : nxt;
   endtask

   task automatic between(input logic [N-1:0] r);
      logic [N-1:0]    a0 = ack_o;
      logic [N*LW-1:0] l0 = link_o;
      @(negedge clk);
      req_i = r;
      @(negedge clk);
      check("R8 hold ack", ack_o == a0, ack_o, a0);
      check("R8 hold link", link_o == l0, link_o, l0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R9 reset ack", ack_o == '0, ack_o, 0);
      check("R9 reset link", link_o == '0, link_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 after release ack", ack_o == '0, ack_o, 0);
      // Pointer 0 after reset: all four request -> inputs 0,1 granted (R3).
      do_slot(4'b1111);
      // Exhaustive pattern sweep, scrambled, many pointer positions.
      for (int k = 0; k < 320; k++) begin
         do_slot(4'((k * 7 + k / 16) % 16));
         if (k % 5 == 0) between(4'((k * 3 + 5) % 16));
      end
      // Idle strobes must keep the pointer: compare against model.
      do_slot(4'b0000);
      do_slot(4'b0000);
      do_slot(4'b1011);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(CLK * 100000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule